// File: doc/BRIEF.md
# Display hot-plug detection sequencer

This block runs the digital side of a periodic presence check on an analog display output. Software sets a detection-enable bit and three interval selects in a small control word. While detection is enabled, a four-state sequencer repeats a fixed pattern. First it powers the sense circuit for a warm-up interval. It keeps the circuit powered through an activation window. At the last cycle of that window it samples two comparator inputs, one for the blue channel and one for the green channel. It then rests for a long interval before the next pass. The comparator and the voltage reference sit outside the block. The block only drives the power request for the sense circuit and an 8-bit reference code picked by a 2-bit threshold select.

The sampled attachment pattern is held in a 2-bit status field, which software clears by writing ones. Whenever a sample changes that field, whether a bit rises or a bit falls, the block emits a one-cycle interrupt request.

States: `ST_OFF` (idle, sense circuit unpowered), `ST_WARM` (warm-up), `ST_ACT` (activation window), `ST_REST` (rest interval). Transitions: OFF→WARM when enable is seen; WARM→ACT when the warm-up count expires; ACT→REST when the activation count expires, which also takes the sample; REST→WARM when the rest count expires; any of WARM, ACT or REST→OFF when enable is 0. Each interval is loaded into one shared down counter on entry, so a state lasts exactly its programmed number of cycles. Interval lengths are parameters, which lets a testbench run with scaled-down counts.

Top module: `hpd_seq`

## Requirements
- R1: With the enable bit (control bit 0) at 0, `sense_on` stays low, `sts_chan` never changes except through clears, and `hp_irq` never pulses.
- R2: The activation window lasts ACT_SHORT cycles when control bit 1 is 0 and ACT_LONG cycles when it is 1 (defaults 64 and 128).
- R3: The warm-up lasts WARM_SHORT cycles when control bit 2 is 0 and WARM_LONG cycles when it is 1 (defaults 2M and 4M).
- R4: The rest interval between passes lasts REST_SHORT cycles when control bit 3 is 0 and REST_LONG cycles when it is 1 (defaults 1G and 2G).
- R5: `sts_chan` bit 0 reports blue and bit 1 reports green (00 none, 01 blue only, 10 green only, 11 both). It takes the sampled value at the same edge on which `sense_on` falls.
- R6: A clear write removes each status bit whose mask bit is 1 and leaves the bits whose mask bit is 0 unchanged. A sample taken in the same cycle as a clear takes priority.
- R7: `hp_irq` pulses for exactly one cycle, at the edge where the status is updated, when a sample changes any status bit. A sample that leaves the status unchanged and a clear write do not raise it.
- R8: Control bits [5:4] select `vref_code` as 0x80, 0xA0, 0xC0 or 0xE0 for the values 0 to 3. The reset value is 01, so the code is 0xA0.
- R9: After reset, `ctl_rdata` reads 0x10, `sts_chan` reads 00, and `hp_irq` and `sense_on` are low.
- R10: In each pass, `sense_on` is high for one contiguous warm-up plus activation span and low for the rest interval.
- R11: Comparator inputs pass through a two-flop synchronizer. Only their synchronized value in the last activation cycle reaches the status, so a pulse that ends earlier in the pass has no effect.
- R12: Clearing the enable bit in the middle of a pass returns the sequencer to OFF. `sense_on` drops on the second edge after the write, and the status keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Detect clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word: [0] enable, [1] long activation, [2] long warm-up, [3] long rest, [5:4] threshold select |
| ctl_rdata | output | 6 | Current control word |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr_mask | input | 2 | Status bits to clear (1 clears) |
| cmp_blue | input | 1 | Asynchronous blue-channel comparator result |
| cmp_green | input | 1 | Asynchronous green-channel comparator result |
| sts_chan | output | 2 | Attached channels: [0] blue, [1] green |
| hp_irq | output | 1 | One-cycle hot-plug interrupt request |
| sense_on | output | 1 | Power request for the sense circuit (warm-up and activation) |
| vref_code | output | 8 | Reference compare code for the external comparator |

## Verification
A wrong interval load or a wrong state transition shows up within one pass as a wrong length of the `sense_on` high or low span. The bench measures both spans for all eight select combinations, and each sum is distinct. A wrong sample moment or a wrong channel order shows up at the falling edge of `sense_on` as a wrong `sts_chan` value. A wrong change-detect term shows up as a missing or extra `hp_irq` pulse in that same cycle. Failing to abort or failing to hold the status shows up two cycles after the enable write, as `sense_on` still high or the status altered.

// File: rtl/hpd_pkg.sv
package hpd_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WARM = 2'd1,
        ST_ACT  = 2'd2,
        ST_REST = 2'd3
    } hpd_state_e;

    // Control word, MSB first: [5:4] thr_sel, [3] rest_long, [2] warm_long,
    // [1] act_long, [0] det_en
    typedef struct packed {
        logic [1:0] thr_sel;
        logic       rest_long;
        logic       warm_long;
        logic       act_long;
        logic       det_en;
    } hpd_ctl_t;

    localparam int          CTL_W   = $bits(hpd_ctl_t);
    localparam int          CHAN_W  = 2;
    localparam logic [5:0]  CTL_RST = 6'h10;

    // Reference code: top bit set, select in bits [6:5]
    function automatic logic [7:0] thr_code(input logic [1:0] sel);
        return {1'b1, sel, 5'b00000};
    endfunction

endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q;
        logic sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= din[g];
                sync_q <= meta_q;
            end
        end
        assign dout[g] = sync_q;
    end

endmodule

// File: rtl/hpd_timer.sv
module hpd_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    AST_TMR_STICKY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && zero) |=> zero); // R10

endmodule

// File: rtl/hpd_regs.sv
module hpd_regs
    import hpd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              clr_we,
    input  logic [CHAN_W-1:0] clr_mask,
    input  logic              smp_stb,
    input  logic [CHAN_W-1:0] smp_chan,
    output hpd_ctl_t          ctl,
    output logic [CHAN_W-1:0] sts,
    output logic              irq
);

    hpd_ctl_t          ctl_q;
    logic [CHAN_W-1:0] sts_q;
    logic              irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= hpd_ctl_t'(CTL_RST);
        end else if (ctl_we) begin
            ctl_q <= hpd_ctl_t'(ctl_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= '0;
            irq_q <= 1'b0;
        end else if (smp_stb) begin
            sts_q <= smp_chan;
            irq_q <= (smp_chan != sts_q);
        end else begin
            irq_q <= 1'b0;
            if (clr_we) begin
                sts_q <= sts_q & ~clr_mask;
            end
        end
    end

    assign ctl = ctl_q;
    assign sts = sts_q;
    assign irq = irq_q;

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q); // R7
    AST_NO_IRQ_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && (smp_chan == sts_q)) |=> !irq_q); // R7
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !smp_stb) |=> ((sts_q & $past(clr_mask)) == '0)); // R6
    AST_STS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_stb && !clr_we) |=> $stable(sts_q)); // R6

endmodule

// File: rtl/hpd_fsm.sv
module hpd_fsm
    import hpd_pkg::*;
#(
    parameter int unsigned WARM_SHORT = 32'd2097152,
    parameter int unsigned WARM_LONG  = 32'd4194304,
    parameter int unsigned ACT_SHORT  = 32'd64,
    parameter int unsigned ACT_LONG   = 32'd128,
    parameter int unsigned REST_SHORT = 32'd1073741824,
    parameter int unsigned REST_LONG  = 32'd2147483648,
    parameter int          CNT_W      = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  hpd_ctl_t         ctl,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             smp_stb,
    output logic             sense_on
);

    localparam logic [CNT_W-1:0] WARM_S_V = CNT_W'(WARM_SHORT - 1);
    localparam logic [CNT_W-1:0] WARM_L_V = CNT_W'(WARM_LONG  - 1);
    localparam logic [CNT_W-1:0] ACT_S_V  = CNT_W'(ACT_SHORT  - 1);
    localparam logic [CNT_W-1:0] ACT_L_V  = CNT_W'(ACT_LONG   - 1);
    localparam logic [CNT_W-1:0] REST_S_V = CNT_W'(REST_SHORT - 1);
    localparam logic [CNT_W-1:0] REST_L_V = CNT_W'(REST_LONG  - 1);

    hpd_state_e       state_q;
    hpd_state_e       state_d;
    logic [CNT_W-1:0] warm_len;
    logic [CNT_W-1:0] act_len;
    logic [CNT_W-1:0] rest_len;

    assign warm_len = ctl.warm_long ? WARM_L_V : WARM_S_V;
    assign act_len  = ctl.act_long  ? ACT_L_V  : ACT_S_V;
    assign rest_len = ctl.rest_long ? REST_L_V : REST_S_V;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state, interval load and sample strobe
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        smp_stb  = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (ctl.det_en) begin
                    state_d  = ST_WARM;
                    tmr_load = 1'b1;
                    tmr_val  = warm_len;
                end
            end
            ST_WARM: begin
                if (!ctl.det_en) begin
                    state_d = ST_OFF;
                end else if (tmr_zero) begin
                    state_d  = ST_ACT;
                    tmr_load = 1'b1;
                    tmr_val  = act_len;
                end
            end
            ST_ACT: begin
                if (!ctl.det_en) begin
                    state_d = ST_OFF;
                end else if (tmr_zero) begin
                    state_d  = ST_REST;
                    tmr_load = 1'b1;
                    tmr_val  = rest_len;
                    smp_stb  = 1'b1;
                end
            end
            ST_REST: begin
                if (!ctl.det_en) begin
                    state_d = ST_OFF;
                end else if (tmr_zero) begin
                    state_d  = ST_WARM;
                    tmr_load = 1'b1;
                    tmr_val  = warm_len;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        sense_on = (state_q == ST_WARM) || (state_q == ST_ACT);
    end

    AST_OFF_WHEN_DIS: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.det_en |=> (state_q == ST_OFF)); // R12
    AST_SMP_ENDS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> (state_q == ST_REST)); // R11
    AST_WARM_FROM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_OFF) && (state_d != ST_OFF)) |=> (state_q == ST_WARM)); // R10

endmodule

// File: rtl/hpd_seq.sv
module hpd_seq
    import hpd_pkg::*;
#(
    parameter int unsigned WARM_SHORT = 32'd2097152,
    parameter int unsigned WARM_LONG  = 32'd4194304,
    parameter int unsigned ACT_SHORT  = 32'd64,
    parameter int unsigned ACT_LONG   = 32'd128,
    parameter int unsigned REST_SHORT = 32'd1073741824,
    parameter int unsigned REST_LONG  = 32'd2147483648
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_we,
    input  logic [5:0]  ctl_wdata,
    output logic [5:0]  ctl_rdata,
    input  logic        sts_clr_we,
    input  logic [1:0]  sts_clr_mask,
    input  logic        cmp_blue,
    input  logic        cmp_green,
    output logic [1:0]  sts_chan,
    output logic        hp_irq,
    output logic        sense_on,
    output logic [7:0]  vref_code
);

    localparam int CNT_W = $clog2(REST_LONG) + 1;

    hpd_ctl_t          ctl;
    logic [CHAN_W-1:0] chan_sync;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic              smp_stb;

    hpd_sync #(.W(CHAN_W)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cmp_green, cmp_blue}),
        .dout  (chan_sync)
    );

    hpd_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    hpd_fsm #(
        .WARM_SHORT (WARM_SHORT),
        .WARM_LONG  (WARM_LONG),
        .ACT_SHORT  (ACT_SHORT),
        .ACT_LONG   (ACT_LONG),
        .REST_SHORT (REST_SHORT),
        .REST_LONG  (REST_LONG),
        .CNT_W      (CNT_W)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .smp_stb  (smp_stb),
        .sense_on (sense_on)
    );

    hpd_regs regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .clr_we    (sts_clr_we),
        .clr_mask  (sts_clr_mask),
        .smp_stb   (smp_stb),
        .smp_chan  (chan_sync),
        .ctl       (ctl),
        .sts       (sts_chan),
        .irq       (hp_irq)
    );

    assign ctl_rdata = ctl;
    assign vref_code = thr_code(ctl.thr_sel);

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        hp_irq |-> $past(ctl.det_en)); // R1
    AST_DARK_WHEN_DIS: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.det_en |=> !sense_on); // R1

endmodule

// File: tb/hpd_seq_tb.sv
module hpd_seq_tb_top;

    localparam int CLK_P = 10;
    localparam int WS = 8,  WL = 16;
    localparam int AS = 4,  AL = 8;
    localparam int RS = 20, RL = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [5:0] ctl_wdata = '0;
    logic [5:0] ctl_rdata;
    logic       sts_clr_we = 1'b0;
    logic [1:0] sts_clr_mask = '0;
    logic       cmp_blue = 1'b0;
    logic       cmp_green = 1'b0;
    logic [1:0] sts_chan;
    logic       hp_irq;
    logic       sense_on;
    logic [7:0] vref_code;

    int total = 0;
    int bad = 0;
    int irq_cnt = 0;
    int irq_run = 0;
    int irq_max = 0;
    int pwr_cnt = 0;

    always #(CLK_P/2) clk = ~clk;

    hpd_seq #(
        .WARM_SHORT (WS), .WARM_LONG (WL),
        .ACT_SHORT  (AS), .ACT_LONG  (AL),
        .REST_SHORT (RS), .REST_LONG (RL)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_we       (ctl_we),
        .ctl_wdata    (ctl_wdata),
        .ctl_rdata    (ctl_rdata),
        .sts_clr_we   (sts_clr_we),
        .sts_clr_mask (sts_clr_mask),
        .cmp_blue     (cmp_blue),
        .cmp_green    (cmp_green),
        .sts_chan     (sts_chan),
        .hp_irq       (hp_irq),
        .sense_on     (sense_on),
        .vref_code    (vref_code)
    );

    always @(negedge clk) begin
        if (hp_irq) begin
            irq_cnt++;
            irq_run++;
            if (irq_run > irq_max) irq_max = irq_run;
        end else begin
            irq_run = 0;
        end
        if (sense_on) pwr_cnt++;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [5:0] v);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic clr(input logic [1:0] m);
        @(negedge clk);
        sts_clr_we = 1'b1;
        sts_clr_mask = m;
        @(negedge clk);
        sts_clr_we = 1'b0;
        sts_clr_mask = '0;
    endtask

    task automatic wait_rise();
        int k = 0;
        while (!sense_on && k < 2000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic count_level(input logic lvl, output int n);
        n = 0;
        while (sense_on == lvl && n < 2000) begin
            n++;
            @(negedge clk);
        end
        #1;
    endtask

    initial begin
        #(CLK_P * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int nh, nl, i0, p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        chk("R9 ctl reset", int'(ctl_rdata), 'h10);
        chk("R9 sts reset", int'(sts_chan), 0);
        chk("R9 irq reset", int'(hp_irq), 0);
        chk("R9 sense reset", int'(sense_on), 0);
        chk("R8 vref reset", int'(vref_code), 'hA0);

        // R8 threshold sweep, enable kept 0
        for (int s = 0; s < 4; s++) begin
            wr_ctl({s[1:0], 4'b0000});
            chk("R8 vref code", int'(vref_code), 'h80 + s * 'h20);
        end

        // R1 disabled: no activity with comparators asserted
        cmp_blue = 1'b1;
        cmp_green = 1'b1;
        repeat (100) @(negedge clk);
        #1;
        chk("R1 no sense while off", pwr_cnt, 0);
        chk("R1 no status while off", int'(sts_chan), 0);
        chk("R1 no irq while off", irq_cnt, 0);

        // R2 R3 R4 R5 R10: all select combinations, all channel patterns
        for (int c = 0; c < 8; c++) begin
            logic [2:0] cb;
            int p, na, nw, nr;
            cb = c[2:0];
            p  = c % 4;
            na = cb[0] ? AL : AS;
            nw = cb[1] ? WL : WS;
            nr = cb[2] ? RL : RS;
            wr_ctl({2'b01, cb[2], cb[1], cb[0], 1'b0});
            repeat (3) @(negedge clk);
            clr(2'b11);
            cmp_blue = p[0];
            cmp_green = p[1];
            repeat (4) @(negedge clk);
            #1;
            i0 = irq_cnt;
            wr_ctl({2'b01, cb[2], cb[1], cb[0], 1'b1});
            wait_rise();
            count_level(1'b1, nh);
            chk("R2 R3 R10 sense high span", nh, nw + na);
            chk("R5 status after pass", int'(sts_chan), p);
            chk("R7 irq on change", irq_cnt - i0, (p != 0) ? 1 : 0);
            count_level(1'b0, nl);
            chk("R4 rest span", nl, nr);
            count_level(1'b1, nh);
            chk("R5 status second pass", int'(sts_chan), p);
            chk("R7 no irq when same", irq_cnt - i0, (p != 0) ? 1 : 0);
        end

        // R11: comparator pulse during warm-up is not captured
        wr_ctl(6'h10);
        repeat (3) @(negedge clk);
        clr(2'b11);
        cmp_blue = 1'b0;
        cmp_green = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        i0 = irq_cnt;
        wr_ctl(6'h11);
        wait_rise();
        @(negedge clk);
        cmp_blue = 1'b1;
        cmp_green = 1'b1;
        repeat (3) @(negedge clk);
        cmp_blue = 1'b0;
        cmp_green = 1'b0;
        count_level(1'b1, nh);
        chk("R11 early pulse ignored", int'(sts_chan), 0);
        chk("R11 no irq from pulse", irq_cnt - i0, 0);

        // R7: falling edge of one bit raises irq; clear raises none
        cmp_blue = 1'b1;
        cmp_green = 1'b1;
        count_level(1'b0, nl);
        count_level(1'b1, nh);
        chk("R5 both attached", int'(sts_chan), 3);
        chk("R7 irq rise", irq_cnt - i0, 1);
        cmp_green = 1'b0;
        count_level(1'b0, nl);
        count_level(1'b1, nh);
        chk("R7 status after unplug", int'(sts_chan), 1);
        chk("R7 irq on falling bit", irq_cnt - i0, 2);
        clr(2'b01);
        #1;
        chk("R6 clear blue", int'(sts_chan), 0);
        chk("R7 no irq from clear", irq_cnt - i0, 2);
        count_level(1'b0, nl);
        count_level(1'b1, nh);
        chk("R7 irq after clear and resample", irq_cnt - i0, 3);
        chk("R5 blue only", int'(sts_chan), 1);

        // R12: abort mid-pass keeps status
        count_level(1'b0, nl);
        repeat (3) @(negedge clk);
        cmp_blue = 1'b0;
        wr_ctl(6'h10);
        @(negedge clk);
        #1;
        chk("R12 sense drops", int'(sense_on), 0);
        p0 = pwr_cnt;
        i0 = irq_cnt;
        repeat (80) @(negedge clk);
        #1;
        chk("R12 status kept", int'(sts_chan), 1);
        chk("R12 stays off", pwr_cnt - p0, 0);
        chk("R1 no irq after abort", irq_cnt - i0, 0);

        // R6: zero mask has no effect, one bit clears
        clr(2'b00);
        #1;
        chk("R6 zero mask no effect", int'(sts_chan), 1);
        clr(2'b10);
        #1;
        chk("R6 other bit mask no effect", int'(sts_chan), 1);
        clr(2'b01);
        #1;
        chk("R6 mask clears", int'(sts_chan), 0);

        chk("R7 irq width", irq_max, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule